// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address to a physical address through two banks of eight block translation entries: one bank serves instruction fetches, the other serves data accesses. Every entry describes one naturally aligned block of memory. It holds a base page, a mask that gives the size of the block, and a physical base. It also holds an enable bit for supervisor mode, an enable bit for user mode, and a two-bit protection code.

A lookup is started with a one-cycle strobe that carries the address and three qualifiers: the bank select, the privilege mode and the access direction. The block then examines one entry per clock, starting at index 0. An entry that covers the address but forbids the access does not end the search. It is passed over, and the next entry is tried. The first entry that both covers the address and allows the access produces a hit. If no entry does, the block reports a miss.

Entries are loaded through a write port, one entry per cycle.

Top module: `bat_xlate`

## Requirements
- R1: After reset all entries have both enable bits cleared and done, hit, miss and busy are low, with phys_addr zero. A lookup made before any entry is loaded ends in a miss.
- R2: When lk_data is 1 the lookup searches the data bank (wr_bank = 1). When lk_data is 0 it searches the instruction bank (wr_bank = 0). Entries in the other bank have no effect on the result.
- R3: An entry takes part in a user-mode lookup (lk_user = 1) only when its user enable bit is set. It takes part in a supervisor-mode lookup (lk_user = 0) only when its supervisor enable bit is set.
- R4: An entry covers the address when (address AND entry mask) equals the entry base.
- R5: On a hit, phys_addr equals the entry's physical base ORed with (address AND NOT mask).
- R6: Protection code 0 allows no access, code 1 allows reads only, and codes 2 and 3 allow reads and writes. On a hit, may_read is 1 and may_write equals bit 1 of the code.
- R7: A covering entry with code 0, or with code 1 on a write lookup, is skipped. The hit comes from the lowest-index entry that is enabled for the mode, covers the address and allows the access.
- R8: An entry is examined once per clock. A hit on entry k makes done, together with hit, rise k+1 clock edges after the edge that accepts the strobe. A miss is reported 8 edges after that edge. done lasts exactly one cycle, and exactly one of hit and miss is high with it.
- R9: A strobe that arrives while a lookup is in progress is ignored. The running lookup keeps its address and produces exactly one result.
- R10: On a miss, phys_addr, may_read and may_write are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry |
| wr_bank | input | 1 | Bank to load: 1 data, 0 instruction |
| wr_idx | input | 3 | Entry index to load |
| wr_base | input | 32 | Base effective page of the entry |
| wr_mask | input | 32 | Block mask of the entry |
| wr_phys | input | 32 | Physical base of the entry |
| wr_sv | input | 1 | Entry enabled in supervisor mode |
| wr_uv | input | 1 | Entry enabled in user mode |
| wr_prot | input | 2 | Protection code |
| lk_start | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Effective address to translate |
| lk_data | input | 1 | 1 data bank, 0 instruction bank |
| lk_user | input | 1 | 1 user mode, 0 supervisor mode |
| lk_write | input | 1 | 1 write access, 0 read access |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Translation found (valid with done) |
| miss | output | 1 | No entry qualified (valid with done) |
| phys_addr | output | 32 | Translated address, held until the next result |
| may_read | output | 1 | Read permission of the hit entry |
| may_write | output | 1 | Write permission of the hit entry |

## Verification
The hardest case to reach is a lookup that must pass over covering entries because of their protection. To hit it, the stimulus puts no-access and read-only entries that cover the same block below a read-write entry. It then issues both a read and a write to that block. The result latency and the reported write permission show which entry won. The ignored strobe is checked by pulsing a hitting address in the middle of a long missing scan. The check then confirms that the result is still a miss, arrives with full miss latency, and is followed by no second result.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int BAT_AW = 32;

  typedef logic [BAT_AW-1:0] bat_addr_t;

  typedef struct packed {
    bat_addr_t   base;
    bat_addr_t   mask;
    bat_addr_t   phys;
    logic        sv;
    logic        uv;
    logic [1:0]  prot;
  } bat_entry_t;

  function automatic logic bat_enabled(input logic sv, input logic uv, input logic user);
    return user ? uv : sv;
  endfunction

  function automatic logic bat_covers(input bat_addr_t addr, input bat_addr_t base,
                                      input bat_addr_t mask);
    return (addr & mask) == base;
  endfunction

  function automatic bat_addr_t bat_map(input bat_addr_t addr, input bat_addr_t phys,
                                        input bat_addr_t mask);
    return phys | (addr & ~mask);
  endfunction

  function automatic logic bat_can_read(input logic [1:0] prot);
    return prot != 2'd0;
  endfunction

  function automatic logic bat_can_write(input logic [1:0] prot);
    return prot[1];
  endfunction
endpackage

// File: rtl/bat_entry_bank.sv
module bat_entry_bank
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  bat_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output bat_entry_t       rd_entry
);
  bat_entry_t ent_arr [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    bat_entry_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_q <= wr_entry;
      end
    end
    assign ent_arr[g] = ent_q;
  end

  assign rd_entry = ent_arr[rd_idx];
endmodule

// File: rtl/bat_qualify.sv
module bat_qualify
  import bat_pkg::*;
(
  input  bat_entry_t ent,
  input  bat_addr_t  addr,
  input  logic       user,
  input  logic       write,
  output logic       qual,
  output bat_addr_t  phys,
  output logic       rd_ok,
  output logic       wr_ok
);
  logic en_ok, cov_ok;

  always_comb begin
    en_ok  = bat_enabled(ent.sv, ent.uv, user);
    cov_ok = bat_covers(addr, ent.base, ent.mask);
    rd_ok  = bat_can_read(ent.prot);
    wr_ok  = bat_can_write(ent.prot);
    phys   = bat_map(addr, ent.phys, ent.mask);
    qual   = en_ok && cov_ok && rd_ok && (!write || wr_ok);
  end
endmodule

// File: rtl/bat_scan_ctl.sv
module bat_scan_ctl #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             qual,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             accept,
  output logic             finish,
  output logic             found
);
  logic last;

  always_comb begin
    accept = start && !busy;
    last   = idx == IDX_W'(NUM_ENT - 1);
    found  = busy && qual;
    finish = busy && (qual || last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int AW = BAT_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_base,
  input  logic [AW-1:0]    wr_mask,
  input  logic [AW-1:0]    wr_phys,
  input  logic             wr_sv,
  input  logic             wr_uv,
  input  logic [1:0]       wr_prot,
  input  logic             lk_start,
  input  logic [AW-1:0]    lk_addr,
  input  logic             lk_data,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             busy,
  output logic             done,
  output logic             hit,
  output logic             miss,
  output logic [AW-1:0]    phys_addr,
  output logic             may_read,
  output logic             may_write
);
  bat_entry_t       wr_entry;
  bat_entry_t       bank_rd [2];
  bat_entry_t       cur_ent;
  logic [IDX_W-1:0] scan_idx;
  logic             accept, finish, found, qual;
  bat_addr_t        addr_q, cand_phys;
  logic             data_q, user_q, write_q;
  logic             cand_rd, cand_wr;

  assign wr_entry = '{base: wr_base, mask: wr_mask, phys: wr_phys,
                      sv: wr_sv, uv: wr_uv, prot: wr_prot};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bat_entry_bank #(.NUM_ENT(NUM_ENT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_bank == b[0])),
      .wr_idx   (wr_idx),
      .wr_entry (wr_entry),
      .rd_idx   (scan_idx),
      .rd_entry (bank_rd[b])
    );
  end

  assign cur_ent = bank_rd[data_q];

  bat_qualify u_qual (
    .ent   (cur_ent),
    .addr  (addr_q),
    .user  (user_q),
    .write (write_q),
    .qual  (qual),
    .phys  (cand_phys),
    .rd_ok (cand_rd),
    .wr_ok (cand_wr)
  );

  bat_scan_ctl #(.NUM_ENT(NUM_ENT)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (lk_start),
    .qual   (qual),
    .busy   (busy),
    .idx    (scan_idx),
    .accept (accept),
    .finish (finish),
    .found  (found)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= 1'b0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= lk_addr;
      data_q  <= lk_data;
      user_q  <= lk_user;
      write_q <= lk_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      phys_addr <= '0;
      may_read  <= 1'b0;
      may_write <= 1'b0;
    end else begin
      done <= finish;
      hit  <= found;
      miss <= finish && !found;
      if (found) begin
        phys_addr <= cand_phys;
        may_read  <= cand_rd;
        may_write <= cand_wr;
      end else if (finish) begin
        phys_addr <= '0;
        may_read  <= 1'b0;
        may_write <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int NUM_ENT = 8,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          hit,
  input logic          miss,
  input logic [AW-1:0] phys_addr,
  input logic          may_read,
  input logic          may_write,
  input logic [AW-1:0] scan_addr,
  input logic          scan_write
);
  localparam int CW = $clog2(NUM_ENT + 2) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hit ^ miss));
  p_no_stray_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!hit && !miss));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_scan_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(NUM_ENT));
  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(scan_addr));
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (phys_addr == '0 && !may_read && !may_write));
  p_hit_readable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> may_read);
  p_write_allowed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && scan_write) |-> may_write);
endmodule

bind bat_xlate bat_xlate_chk #(.NUM_ENT(NUM_ENT), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .hit        (hit),
  .miss       (miss),
  .phys_addr  (phys_addr),
  .may_read   (may_read),
  .may_write  (may_write),
  .scan_addr  (addr_q),
  .scan_write (write_q)
);

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0, wr_sv = 1'b0, wr_uv = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_base = '0, wr_mask = '0, wr_phys = '0;
  logic [1:0]  wr_prot = '0;
  logic        lk_start = 1'b0, lk_data = 1'b0, lk_user = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        busy, done, hit, miss, may_read, may_write;
  logic [31:0] phys_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bat_xlate u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic bank, input int idx, input logic [31:0] base,
                      input logic [31:0] mask, input logic [31:0] phys,
                      input logic sv, input logic uv, input logic [1:0] prot);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank; wr_idx = 3'(idx);
    wr_base = base; wr_mask = mask; wr_phys = phys;
    wr_sv = sv; wr_uv = uv; wr_prot = prot;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Lookup; lat counts negedges from the one after the strobe until done is seen.
  // Hit on entry k gives lat = k + 2, a miss gives lat = 9.
  task automatic lookup(input logic [31:0] addr, input logic data, input logic user,
                        input logic write, output int lat);
    @(negedge clk);
    lk_start = 1'b1; lk_addr = addr; lk_data = data; lk_user = user; lk_write = write;
    @(negedge clk);
    lk_start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_result(input string req, input int lat, input int exp_lat,
                               input logic exp_hit, input logic [31:0] exp_phys,
                               input logic exp_wr);
    check({req, " latency"}, 32'(lat), 32'(exp_lat));
    check({req, " hit"}, {31'b0, hit}, {31'b0, exp_hit});
    check({req, " miss"}, {31'b0, miss}, {31'b0, !exp_hit});
    check({req, " phys"}, phys_addr, exp_phys);
    check({req, " may_read"}, {31'b0, may_read}, {31'b0, exp_hit});
    check({req, " may_write"}, {31'b0, may_write}, {31'b0, exp_wr});
    @(negedge clk);
    check({req, " done pulse R8"}, {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset();
    int lat;
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 hit/miss", {30'b0, hit, miss}, 32'd0);
    check("R1 phys", phys_addr, 32'd0);
    lookup(32'h0000_0000, 1'b1, 1'b0, 1'b0, lat);
    expect_result("R1 empty data", lat, 9, 1'b0, 32'd0, 1'b0);
    lookup(32'h0000_0000, 1'b0, 1'b1, 1'b0, lat);
    expect_result("R1 empty inst", lat, 9, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_basic();
    int lat;
    load(1'b1, 2, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 1'b1, 1'b0, 2'd2);
    lookup(32'h1234_5678, 1'b1, 1'b0, 1'b0, lat);
    expect_result("R4 R5 R8 basic hit", lat, 4, 1'b1, 32'h8234_5678, 1'b1);
    lookup(32'h3000_0000, 1'b1, 1'b0, 1'b0, lat);
    expect_result("R4 R10 no cover", lat, 9, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_bank();
    int lat;
    lookup(32'h1234_5678, 1'b0, 1'b0, 1'b0, lat);
    expect_result("R2 inst bank ignores data", lat, 9, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_mode();
    int lat;
    lookup(32'h1234_5678, 1'b1, 1'b1, 1'b0, lat);
    expect_result("R3 user blocked", lat, 9, 1'b0, 32'd0, 1'b0);
    load(1'b0, 0, 32'h2000_0000, 32'hF000_0000, 32'h4000_0000, 1'b0, 1'b1, 2'd3);
    lookup(32'h2ABC_DEF0, 1'b0, 1'b1, 1'b1, lat);
    expect_result("R3 user enabled", lat, 2, 1'b1, 32'h4ABC_DEF0, 1'b1);
    lookup(32'h2ABC_DEF0, 1'b0, 1'b0, 1'b0, lat);
    expect_result("R3 supervisor blocked", lat, 9, 1'b0, 32'd0, 1'b0);
    lookup(32'h2ABC_DEF0, 1'b1, 1'b1, 1'b0, lat);
    expect_result("R2 data bank ignores inst", lat, 9, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_protect();
    int lat;
    load(1'b1, 0, 32'h1000_0000, 32'hF000_0000, 32'hA000_0000, 1'b1, 1'b0, 2'd0);
    lookup(32'h1000_0010, 1'b1, 1'b0, 1'b0, lat);
    expect_result("R6 R7 code0 skipped", lat, 4, 1'b1, 32'h8000_0010, 1'b1);
    load(1'b1, 1, 32'h1000_0000, 32'hF000_0000, 32'h9000_0000, 1'b1, 1'b0, 2'd1);
    lookup(32'h1000_0010, 1'b1, 1'b0, 1'b0, lat);
    expect_result("R6 R7 read-only read", lat, 3, 1'b1, 32'h9000_0010, 1'b0);
    lookup(32'h1000_0010, 1'b1, 1'b0, 1'b1, lat);
    expect_result("R6 R7 read-only write skipped", lat, 4, 1'b1, 32'h8000_0010, 1'b1);
  endtask

  task automatic t_small_block();
    int lat;
    load(1'b1, 7, 32'h5002_0000, 32'hFFFE_0000, 32'h0010_0000, 1'b1, 1'b1, 2'd3);
    lookup(32'h5003_ABCD, 1'b1, 1'b1, 1'b1, lat);
    expect_result("R5 R8 last entry", lat, 9, 1'b1, 32'h0011_ABCD, 1'b1);
    lookup(32'h5004_0000, 1'b1, 1'b1, 1'b0, lat);
    expect_result("R4 outside block", lat, 9, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_busy_strobe();
    int lat;
    @(negedge clk);
    lk_start = 1'b1; lk_addr = 32'h3000_0000; lk_data = 1'b1; lk_user = 1'b0; lk_write = 1'b0;
    @(negedge clk);
    lk_start = 1'b0;
    lat = 1;
    @(negedge clk); lat++;
    lk_start = 1'b1; lk_addr = 32'h1234_5678;
    @(negedge clk); lat++;
    lk_start = 1'b0;
    check("R9 busy during scan", {31'b0, busy}, 32'd1);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    expect_result("R9 strobe ignored", lat, 9, 1'b0, 32'd0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) check("R9 no second result", 32'd1, 32'd0);
    end
    check("R9 idle after", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bank();
    t_mode();
    t_protect();
    t_small_block();
    t_busy_strobe();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule